// File: doc/BRIEF.md
# Two-Bank GPIO Port Core with Interrupt-on-Change

This core implements sixteen general-purpose I/O pins arranged as two banks of eight (bank A holds pins 0 to 7, bank B holds pins 8 to 15). A simple synchronous register bus reaches a per-bank register set, and the core drives a value, an output enable and a pull-up enable for every pin. Pin inputs are synchronized and can be inverted per pin. Each bank watches its inputs for changes, or for mismatches against a compare value, and raises its own interrupt output.

Each bank records only one triggering pin at a time: the lowest-numbered qualifying pin. It freezes a snapshot of its port at that moment and holds both until software performs the clearing read. A configuration register selects which read clears the interrupt (port or snapshot), the active level of the interrupt outputs, open-drain drive, and whether the two bank outputs are merged. The serial front-end that turns bus transactions into the register strobes used here lies outside this block.

Top module: `gpio_ioc_core`

## Requirements
- R1: After reset the direction registers read 0xFF (all pins are inputs, `pin_oe` all 0). Every other register reads 0x00. Both interrupt outputs are inactive: `irq_out`=1 with `irq_oe`=1, because the outputs default to push-pull and active-low.
- R2: The byte address is 2*offset + bank, where bank A=0 and bank B=1. The offsets are: 0 direction, 1 polarity, 2 interrupt enable, 3 compare value, 4 compare-mode select, 5 configuration, 6 pull-up, 7 flag, 8 snapshot, 9 port, 10 latch. Read data appears on `bus_rdata` on the cycle after `bus_re` and is held there. Addresses 0x16 and above read 0x00, and writes to them are ignored.
- R3: `pin_out` follows the latch, `pin_oe` is the inverse of the direction bits, and `pin_pu` follows the pull-up register. A write to the port address loads the latch.
- R4: A port read returns the synchronized pin value XOR the polarity bits. The pin must be stable for two clocks before the read sees it.
- R5: With compare-mode bit 0, an enabled pin whose polarity-adjusted value changes sets its flag. The flag is set on the third rising edge after the pin change. Disabled pins never set a flag.
- R6: With compare-mode bit 1, an enabled pin sets its flag whenever its value differs from its compare bit. The condition re-raises the flag at the clearing read for as long as the mismatch persists.
- R7: Each bank's flag register has at most one bit set, the lowest-numbered qualifying pin. The two banks flag independently in the same cycle.
- R8: When a flag is set, the snapshot register takes the bank's port value. Flag and snapshot stay frozen until the clearing read, even if more pins change.
- R9: Configuration bit 0 = 0: a port read clears that bank's flag and a snapshot read does not. Bit 0 = 1: the reverse. A clear affects only the addressed bank.
- R10: Configuration bit 1 = 1 makes an interrupt output active-high. In push-pull mode the inactive level is the inverse of the active level.
- R11: Configuration bit 2 = 1 selects open-drain. `irq_oe` is 1 only while that output is active, and `irq_out` is 0 throughout.
- R12: Configuration bit 6 = 1 drives both interrupt outputs from the OR of the two banks' pending state.
- R13: One configuration register is reachable at both 0x0A and 0x0B. Bits 5 and 3 are stored and read back, and they have no effect inside the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (also triggers clearing side effect) |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| pin_pu | output | 16 | Pin pull-up enables |
| irq_out | output | 2 | Interrupt output level, bit 0 bank A, bit 1 bank B |
| irq_oe | output | 2 | Interrupt output enable |

## Verification
Several properties are checked on every cycle:
- Each flag register stays one-hot or zero.
- A pending flag and its snapshot do not move until the clearing read.
- A newly set flag only names pins that were enabled.
- Mirrored outputs are identical, and open-drain outputs never drive high.
- Unmapped reads return zero.

Other behaviours can only be shown by the bench scenarios:
- The three-edge latency from pin change to flag.
- Lowest-pin selection when several pins move together.
- Which read clears under each setting of the clear-source bit.
- Re-assertion in compare-value mode.
- Reset values.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int OFF_W     = 4;
    localparam int ADDR_W    = OFF_W + BANK_BITS;
    localparam int PIN_W     = DATA_W * NUM_BANKS;

    localparam logic [OFF_W-1:0] OFF_DIR  = 4'd0;
    localparam logic [OFF_W-1:0] OFF_POL  = 4'd1;
    localparam logic [OFF_W-1:0] OFF_IEN  = 4'd2;
    localparam logic [OFF_W-1:0] OFF_CMPV = 4'd3;
    localparam logic [OFF_W-1:0] OFF_CMPM = 4'd4;
    localparam logic [OFF_W-1:0] OFF_CFG  = 4'd5;
    localparam logic [OFF_W-1:0] OFF_PUP  = 4'd6;
    localparam logic [OFF_W-1:0] OFF_FLAG = 4'd7;
    localparam logic [OFF_W-1:0] OFF_SNAP = 4'd8;
    localparam logic [OFF_W-1:0] OFF_PORT = 4'd9;
    localparam logic [OFF_W-1:0] OFF_LAT  = 4'd10;

    localparam int CFG_CLR_SNAP = 0;
    localparam int CFG_ACT_HIGH = 1;
    localparam int CFG_OPEN_DRN = 2;
    localparam int CFG_MIRROR   = 6;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_d[g];
            end
        end
    endgenerate

    assign q_out = st_q[STAGES-1];
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [W-1:0]     wdata,
    input  logic             clr,
    input  logic [W-1:0]     pin_sync,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     lat_out,
    output logic [W-1:0]     oe_out,
    output logic [W-1:0]     pup_out,
    output logic             pending
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] pol;
        logic [W-1:0] ien;
        logic [W-1:0] cmpv;
        logic [W-1:0] cmpm;
        logic [W-1:0] pup;
        logic [W-1:0] lat;
        logic [W-1:0] flag;
        logic [W-1:0] snap;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t r_d, r_q;
    logic [W-1:0] cur;
    logic [W-1:0] trig;
    logic [W-1:0] first;
    logic         hold;

    always_comb begin
        cur   = pin_sync ^ r_q.pol;
        trig  = r_q.ien & ((r_q.cmpm & (cur ^ r_q.cmpv)) | (~r_q.cmpm & (cur ^ r_q.prev)));
        first = trig & (~trig + 1'b1);
        hold  = (r_q.flag != '0) && !clr;

        r_d      = r_q;
        r_d.prev = cur;
        if (wr_en) begin
            case (acc_off)
                OFF_DIR:  r_d.dir  = wdata;
                OFF_POL:  r_d.pol  = wdata;
                OFF_IEN:  r_d.ien  = wdata;
                OFF_CMPV: r_d.cmpv = wdata;
                OFF_CMPM: r_d.cmpm = wdata;
                OFF_PUP:  r_d.pup  = wdata;
                OFF_PORT: r_d.lat  = wdata;
                OFF_LAT:  r_d.lat  = wdata;
                default:  ;
            endcase
        end
        if (!hold) begin
            if (trig != '0) begin
                r_d.flag = first;
                r_d.snap = cur;
            end else begin
                r_d.flag = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dir <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (acc_off)
            OFF_DIR:  rd_data = r_q.dir;
            OFF_POL:  rd_data = r_q.pol;
            OFF_IEN:  rd_data = r_q.ien;
            OFF_CMPV: rd_data = r_q.cmpv;
            OFF_CMPM: rd_data = r_q.cmpm;
            OFF_PUP:  rd_data = r_q.pup;
            OFF_FLAG: rd_data = r_q.flag;
            OFF_SNAP: rd_data = r_q.snap;
            OFF_PORT: rd_data = cur;
            OFF_LAT:  rd_data = r_q.lat;
            default:  rd_data = '0;
        endcase
    end

    assign lat_out = r_q.lat;
    assign oe_out  = ~r_q.dir;
    assign pup_out = r_q.pup;
    assign pending = (r_q.flag != '0);

    // R7
    flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.flag));

    // R8
    frozen_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag != '0 && !clr) |=> ($stable(r_q.flag) && $stable(r_q.snap)));

    // R5
    flag_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag != '0 && r_q.flag != $past(r_q.flag)) |-> ((r_q.flag & ~$past(r_q.ien)) == '0));
endmodule

// File: rtl/gpx_irq_drv.sv
module gpx_irq_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic act_high,
    input  logic open_drain,
    output logic drv_out,
    output logic drv_oe
);
    always_comb begin
        if (open_drain) begin
            drv_out = 1'b0;
            drv_oe  = active;
        end else begin
            drv_oe  = 1'b1;
            drv_out = active ? act_high : ~act_high;
        end
    end

    // R11
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_drain |-> (!drv_out && (drv_oe == active)));

    // R10
    pp_always_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_drain |-> (drv_oe && (drv_out == (active == act_high))));
endmodule

// File: rtl/gpio_ioc_core.sv
module gpio_ioc_core
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_pu,
    output logic [NUM_BANKS-1:0] irq_out,
    output logic [NUM_BANKS-1:0] irq_oe
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((int'(OFF_LAT) + 1) * NUM_BANKS - 1);

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [OFF_W-1:0]     off;
    logic [BANK_BITS-1:0] bsel;
    logic                 addr_ok;
    logic [OFF_W-1:0]     clr_off;
    logic [PIN_W-1:0]     pin_sync;
    logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_wr;
    logic [NUM_BANKS-1:0] bank_clr;
    logic [NUM_BANKS-1:0] bank_pend;
    logic [NUM_BANKS-1:0] irq_act;

    assign off     = bus_addr[ADDR_W-1:BANK_BITS];
    assign bsel    = bus_addr[BANK_BITS-1:0];
    assign addr_ok = (bus_addr <= LAST_ADDR);
    assign clr_off = s_q.cfg[CFG_CLR_SNAP] ? OFF_SNAP : OFF_PORT;

    gpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_wr[b]  = bus_we && addr_ok && (int'(bsel) == b) && (off != OFF_CFG);
            assign bank_clr[b] = bus_re && addr_ok && (int'(bsel) == b) && (off == clr_off);

            gpx_bank #(.W(DATA_W)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (bank_wr[b]),
                .acc_off  (off),
                .wdata    (bus_wdata),
                .clr      (bank_clr[b]),
                .pin_sync (pin_sync[b*DATA_W +: DATA_W]),
                .rd_data  (bank_rd[b]),
                .lat_out  (pin_out[b*DATA_W +: DATA_W]),
                .oe_out   (pin_oe[b*DATA_W +: DATA_W]),
                .pup_out  (pin_pu[b*DATA_W +: DATA_W]),
                .pending  (bank_pend[b])
            );

            assign irq_act[b] = s_q.cfg[CFG_MIRROR] ? (|bank_pend) : bank_pend[b];

            gpx_irq_drv u_irq (
                .clk        (clk),
                .rst_n      (rst_n),
                .active     (irq_act[b]),
                .act_high   (s_q.cfg[CFG_ACT_HIGH]),
                .open_drain (s_q.cfg[CFG_OPEN_DRN]),
                .drv_out    (irq_out[b]),
                .drv_oe     (irq_oe[b])
            );
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (bus_we && addr_ok && off == OFF_CFG) begin
            s_d.cfg = bus_wdata;
        end
        if (bus_re) begin
            if (!addr_ok)            s_d.rdata = '0;
            else if (off == OFF_CFG) s_d.rdata = s_q.cfg;
            else                     s_d.rdata = bank_rd[bsel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;

    // R2
    bad_addr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !addr_ok) |=> (bus_rdata == '0));

    // R12
    mirror_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg[CFG_MIRROR] |-> (irq_out[0] == irq_out[1] && irq_oe[0] == irq_oe[1]));
endmodule

// File: tb/sim_gpio_ioc_core.sv
module sim_gpio_ioc_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_pu;
    logic [1:0]  irq_out, irq_oe;

    int checks = 0;
    int fails  = 0;

    gpio_ioc_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] low1(input logic [7:0] x);
        return x & (~x + 8'd1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle(input logic [15:0] v);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pa, pb;
        logic [15:0] p0, p1;
        logic [7:0] ia, ib, da, db;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1 dirA", v, 8'hFF);
        rd(5'h01, v); chk("R1 dirB", v, 8'hFF);
        chk("R1 pin_oe", pin_oe, 16'h0000);
        rd(5'h04, v); chk("R1 ienA", v, 8'h00);
        rd(5'h0A, v); chk("R1 cfg", v, 8'h00);
        rd(5'h15, v); chk("R1 latB", v, 8'h00);
        chk("R1 irq_out", irq_out, 2'b11);
        chk("R1 irq_oe", irq_oe, 2'b11);

        // R3 pin outputs
        wr(5'h00, 8'h0F); wr(5'h12, 8'hA5); wr(5'h15, 8'h3C); wr(5'h0D, 8'h81);
        chk("R3 pin_out", pin_out, 16'h3CA5);
        chk("R3 pin_oe", pin_oe, 16'h00F0);
        chk("R3 pin_pu", pin_pu, 16'h8100);
        rd(5'h14, v); chk("R3 port write loads latch", v, 8'hA5);

        // R2 random readback and unmapped addresses
        for (int i = 0; i < 20; i++) begin
            logic [4:0] a;
            logic [7:0] d;
            case ($urandom % 4)
                0: a = 5'h00; 1: a = 5'h06; 2: a = 5'h0C; default: a = 5'h14;
            endcase
            a = a | 5'($urandom % 2);
            d = 8'($urandom);
            wr(a, d);
            rd(a, v); chk("R2 readback", v, d);
        end
        wr(5'h17, 8'h55);
        rd(5'h17, v); chk("R2 unmapped read", v, 8'h00);
        rd(5'h1F, v); chk("R2 unmapped read hi", v, 8'h00);

        // R4 polarity and synchronizer
        for (int i = 0; i < 10; i++) begin
            pa = 8'($urandom); pb = 8'($urandom);
            wr(5'h02, pa); wr(5'h03, pb);
            p0 = 16'($urandom);
            settle(p0);
            rd(5'h12, v); chk("R4 portA", v, p0[7:0] ^ pa);
            rd(5'h13, v); chk("R4 portB", v, p0[15:8] ^ pb);
        end

        // R5 R7 R8 random change-detect scenarios
        for (int i = 0; i < 25; i++) begin
            wr(5'h04, 8'h00); wr(5'h05, 8'h00);
            wr(5'h08, 8'h00); wr(5'h09, 8'h00);
            pa = 8'($urandom); pb = 8'($urandom);
            wr(5'h02, pa); wr(5'h03, pb);
            p0 = 16'($urandom);
            settle(p0);
            rd(5'h12, v); rd(5'h13, v);
            ia = 8'($urandom); ib = 8'($urandom);
            wr(5'h04, ia); wr(5'h05, ib);
            p1 = 16'($urandom);
            settle(p1);
            da = (p1[7:0] ^ p0[7:0]) & ia;
            db = (p1[15:8] ^ p0[15:8]) & ib;
            chk("R5 irqA level", irq_out[0], (da == 8'h00));
            chk("R5 irqB level", irq_out[1], (db == 8'h00));
            rd(5'h0E, v); chk("R7 flagA lowest", v, low1(da));
            rd(5'h0F, v); chk("R7 flagB lowest", v, low1(db));
            if (da != 8'h00) begin rd(5'h10, v); chk("R8 snapA", v, p1[7:0] ^ pa); end
            if (db != 8'h00) begin rd(5'h11, v); chk("R8 snapB", v, p1[15:8] ^ pb); end
        end

        // R7 directed: two pins in A, one in B
        wr(5'h04, 8'h00); wr(5'h05, 8'h00);
        wr(5'h02, 8'h00); wr(5'h03, 8'h00);
        settle(16'h0000);
        rd(5'h12, v); rd(5'h13, v);
        wr(5'h04, 8'hFF); wr(5'h05, 8'hFF);
        settle(16'h0224);
        rd(5'h0E, v); chk("R7 flagA two pins", v, 8'h04);
        rd(5'h0F, v); chk("R7 flagB same cycle", v, 8'h02);
        rd(5'h10, v); chk("R8 snapA", v, 8'h24);

        // R8 frozen while pending
        settle(16'h0264);
        rd(5'h0E, v); chk("R8 flagA frozen", v, 8'h04);
        rd(5'h10, v); chk("R8 snapA frozen", v, 8'h24);

        // R9 clear source = port
        rd(5'h10, v);
        rd(5'h0E, v); chk("R9 snap read keeps flag", v, 8'h04);
        rd(5'h12, v); chk("R9 port value", v, 8'h64);
        rd(5'h0E, v); chk("R9 port read clears A", v, 8'h00);
        rd(5'h0F, v); chk("R9 B untouched", v, 8'h02);
        chk("R9 irq levels", irq_out, 2'b01);

        // R9 clear source = snapshot
        wr(5'h0A, 8'h01);
        settle(16'h0265);
        rd(5'h0E, v); chk("R9 new flagA", v, 8'h01);
        rd(5'h12, v);
        rd(5'h0E, v); chk("R9 port read keeps flag", v, 8'h01);
        rd(5'h10, v); chk("R9 snap value", v, 8'h65);
        rd(5'h0E, v); chk("R9 snap read clears A", v, 8'h00);
        rd(5'h11, v);
        rd(5'h0F, v); chk("R9 snap read clears B", v, 8'h00);

        // R10 active-high
        wr(5'h0A, 8'h02);
        chk("R10 idle low", irq_out, 2'b00);
        settle(16'h0266);
        chk("R10 A active high", irq_out, 2'b01);

        // R12 mirror
        wr(5'h0A, 8'h42);
        chk("R12 mirrored", irq_out, 2'b11);

        // R11 open-drain
        wr(5'h0A, 8'h44);
        chk("R11 od out", irq_out, 2'b00);
        chk("R11 od oe mirrored", irq_oe, 2'b11);
        wr(5'h0A, 8'h04);
        chk("R11 od oe per bank", irq_oe, 2'b01);
        rd(5'h12, v);
        chk("R11 od released", irq_oe, 2'b00);

        // R13 shared config
        wr(5'h0B, 8'h28);
        rd(5'h0A, v); chk("R13 cfg via A", v, 8'h28);
        rd(5'h0B, v); chk("R13 cfg via B", v, 8'h28);
        chk("R13 bits 5,3 inert", irq_out, 2'b11);
        wr(5'h0A, 8'h00);

        // R6 compare-value mode
        wr(5'h05, 8'h00);
        wr(5'h04, 8'h01);
        wr(5'h08, 8'h01);
        rd(5'h0E, v); chk("R6 equal no flag", v, 8'h00);
        wr(5'h06, 8'h01);
        @(negedge clk);
        rd(5'h0E, v); chk("R6 mismatch flag", v, 8'h01);
        rd(5'h12, v);
        rd(5'h0E, v); chk("R6 re-raised", v, 8'h01);
        settle(16'h0267);
        rd(5'h12, v);
        rd(5'h0E, v); chk("R6 match clears", v, 8'h00);
        chk("R6 irq idle", irq_out[0], 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule